// File: doc/BRIEF.md
# Protection Fault Latch and Thermal Alarm

This block sits beside a power-stage driver and turns three raw comparator
outputs into protection actions. An over-current input and a thermal-shutdown
input each pass through their own digital deglitch counter on the system
clock. Once either is accepted, the block disables the power outputs and pulls
the error flag low. It keeps both until the part enters standby or sees a
power-on reset.

A third input, the thermal-alarm threshold, has its own, different masking
count. It drives a separate warning flag that never latches. The flag drops
back on its own once a separate release input reports that the die has cooled
below the lower threshold. Both flags are open-drain: each one is modelled as a
drive-low enable that is high while the pad should sink current.

Two state machines carry the behaviour. The fault machine has the states
SLEEP, RUN and TRIP. Its transitions are:
- SLEEP to RUN when standby is released.
- RUN to TRIP when a qualified fault is present.
- TRIP to SLEEP, or RUN to SLEEP, when standby is entered.

There is no edge out of TRIP other than standby or power-on reset. The alarm
machine has the states IDLE and WARN. IDLE goes to WARN on a qualified alarm
while the release input is low. WARN goes to IDLE when the release input is
high, and either state goes to IDLE in standby.

Top module: `prot_guard`

## Requirements
- R1: An over-current input held high for OC_MASK (default 8) consecutive rising clock edges is accepted. `err_pull_low` and `out_disable` go high after the following edge, edge OC_MASK+1. After edge OC_MASK they are still low.
- R2: A thermal-shutdown input held high for TSD_MASK (default 32) consecutive edges trips the fault machine after edge TSD_MASK+1. After edge TSD_MASK the outputs are still clear.
- R3: A raw input that falls before its mask count completes restarts its counter from zero. Two runs of MASK-1 high samples separated by one low sample never cause a trip.
- R4: Once tripped, `err_pull_low` and `out_disable` stay high after the raw fault inputs return low, for as long as standby is not entered.
- R5: `err_pull_low` is high only when `out_disable` is also high.
- R6: When `standby_n` is sampled low, the next edge enters SLEEP. In SLEEP, `out_disable` is 1, `err_pull_low` is 0 and `alm_pull_low` is 0. All deglitch counters are held at zero, so a fault input that was high during standby needs a full mask count after standby ends. The first edge with `standby_n` high enters RUN, and `out_disable` then reads 0.
- R7: While `por_n` is low, the block is asynchronously in SLEEP and the alarm is IDLE. `out_disable` reads 1 and both flags read 0. A latched trip is cleared by this reset.
- R8: A thermal-alarm input held high for ALM_MASK (default 16) edges raises `alm_pull_low` after edge ALM_MASK+1. The alarm does not change `out_disable` or `err_pull_low`. It stays high after the alarm input falls, and clears one edge after `alm_cool` is sampled high.
- R9: While `alm_cool` is high, a qualified alarm input does not enter WARN. When `alm_cool` falls with the alarm already qualified, WARN is entered on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| standby_n | input | 1 | Low requests standby; clears latched faults |
| oc_raw | input | 1 | Raw over-current comparator output |
| tsd_raw | input | 1 | Raw thermal-shutdown comparator output |
| alm_hot | input | 1 | Raw thermal-alarm assert threshold crossed |
| alm_cool | input | 1 | Raw thermal-alarm release threshold reached |
| out_disable | output | 1 | High turns off all power output transistors |
| err_pull_low | output | 1 | Drive-low enable of the open-drain error flag |
| alm_pull_low | output | 1 | Drive-low enable of the open-drain alarm flag |

## Verification
Each fault input is held high for exactly its mask count and then one edge
more, which separates an off-by-one counter from a correct one on every
source. A pair of runs one sample short of the mask, with one low sample
between them, tells a counter that restarts apart from one that merely pauses.
A fault held high through a whole standby period shows whether the counters
are truly held or only the outputs are masked. The alarm is driven with a
release input that overlaps it and with one that follows it, which separates
the self-recovering warning from the latched faults and checks the priority of
release over assert.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [1:0] {
        FS_SLEEP = 2'd0,
        FS_RUN   = 2'd1,
        FS_TRIP  = 2'd2
    } fault_st_t;

    typedef enum logic {
        AS_IDLE = 1'b0,
        AS_WARN = 1'b1
    } alarm_st_t;

    function automatic int cnt_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/prot_deglitch.sv
module prot_deglitch #(
    parameter int MASK = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic raw,
    output logic qual
);
    import prot_pkg::*;

    localparam int CW = cnt_width(MASK);
    localparam logic [CW-1:0] LIMIT = CW'(MASK);

    logic [CW-1:0] run_cnt;

    // Consecutive-sample counter, saturating at the mask limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (hold || !raw) begin
            run_cnt <= '0;
        end else if (run_cnt != LIMIT) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign qual = (run_cnt == LIMIT);

endmodule

// File: rtl/prot_fault_fsm.sv
module prot_fault_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic awake,
    input  logic trip_req,
    output logic out_disable,
    output logic err_pull_low
);
    import prot_pkg::*;

    fault_st_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_SLEEP: if (awake) state_d = FS_RUN;
            FS_RUN: begin
                if (!awake)        state_d = FS_SLEEP;
                else if (trip_req) state_d = FS_TRIP;
            end
            FS_TRIP:  if (!awake) state_d = FS_SLEEP;
            default:  state_d = FS_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_SLEEP;
        else        state_q <= state_d;
    end

    always_comb begin
        out_disable  = 1'b1;
        err_pull_low = 1'b0;
        unique case (state_q)
            FS_SLEEP: begin
                out_disable  = 1'b1;
                err_pull_low = 1'b0;
            end
            FS_RUN: begin
                out_disable  = 1'b0;
                err_pull_low = 1'b0;
            end
            FS_TRIP: begin
                out_disable  = 1'b1;
                err_pull_low = 1'b1;
            end
            default: begin
                out_disable  = 1'b1;
                err_pull_low = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/prot_alarm_fsm.sv
module prot_alarm_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic awake,
    input  logic hot_q,
    input  logic cool,
    output logic alm_pull_low
);
    import prot_pkg::*;

    alarm_st_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AS_IDLE: if (awake && hot_q && !cool) state_d = AS_WARN;
            AS_WARN: if (!awake || cool)          state_d = AS_IDLE;
            default: state_d = AS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        alm_pull_low = 1'b0;
        unique case (state_q)
            AS_IDLE: alm_pull_low = 1'b0;
            AS_WARN: alm_pull_low = 1'b1;
            default: alm_pull_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/prot_guard.sv
module prot_guard #(
    parameter int OC_MASK  = 8,
    parameter int TSD_MASK = 32,
    parameter int ALM_MASK = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic standby_n,
    input  logic oc_raw,
    input  logic tsd_raw,
    input  logic alm_hot,
    input  logic alm_cool,
    output logic out_disable,
    output logic err_pull_low,
    output logic alm_pull_low
);
    localparam int NSRC = 3;

    logic [NSRC-1:0] raw_vec;
    logic [NSRC-1:0] qual_vec;
    logic            hold_cnt;

    assign raw_vec  = {alm_hot, tsd_raw, oc_raw};
    assign hold_cnt = !standby_n;

    // Index 0: over-current, 1: shutdown, 2: alarm.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam int M = (g == 0) ? OC_MASK : ((g == 1) ? TSD_MASK : ALM_MASK);
        prot_deglitch #(.MASK(M)) u_dg (
            .clk   (clk),
            .rst_n (por_n),
            .hold  (hold_cnt),
            .raw   (raw_vec[g]),
            .qual  (qual_vec[g])
        );
    end

    prot_fault_fsm u_fault (
        .clk          (clk),
        .rst_n        (por_n),
        .awake        (standby_n),
        .trip_req     (qual_vec[0] | qual_vec[1]),
        .out_disable  (out_disable),
        .err_pull_low (err_pull_low)
    );

    prot_alarm_fsm u_alarm (
        .clk          (clk),
        .rst_n        (por_n),
        .awake        (standby_n),
        .hot_q        (qual_vec[2]),
        .cool         (alm_cool),
        .alm_pull_low (alm_pull_low)
    );

endmodule

// File: rtl/prot_guard_chk.sv
module prot_guard_chk (
    input logic clk,
    input logic por_n,
    input logic standby_n,
    input logic oc_raw,
    input logic tsd_raw,
    input logic alm_hot,
    input logic alm_cool,
    input logic out_disable,
    input logic err_pull_low,
    input logic alm_pull_low
);

    // R4: a trip holds while standby stays high
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
        (err_pull_low && standby_n) |=> err_pull_low);

    // R5: error flag implies outputs disabled
    p_err_disables_r5: assert property (@(posedge clk) disable iff (!por_n)
        err_pull_low |-> out_disable);

    // R6: standby forces the safe state on the next edge
    p_standby_safe_r6: assert property (@(posedge clk) disable iff (!por_n)
        !standby_n |=> (out_disable && !err_pull_low && !alm_pull_low));

    // R1 and R2: a trip needs a fault input high at the qualifying edge
    p_trip_cause_r1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(err_pull_low) |-> $past(oc_raw || tsd_raw, 2));

    // R8: release input clears the alarm on the next edge
    p_alarm_release_r8: assert property (@(posedge clk) disable iff (!por_n)
        alm_cool |=> !alm_pull_low);

    // R9: no alarm entry while the release input is high
    p_cool_blocks_r9: assert property (@(posedge clk) disable iff (!por_n)
        (alm_cool && !alm_pull_low) |=> !alm_pull_low);

endmodule

bind prot_guard prot_guard_chk u_chk (.*);

// File: tb/prot_guard_tb.sv
module prot_guard_tb;

    localparam int OCM  = 8;
    localparam int TSDM = 32;
    localparam int ALMM = 16;

    logic clk = 1'b0;
    logic por_n, standby_n, oc_raw, tsd_raw, alm_hot, alm_cool;
    logic out_disable, err_pull_low, alm_pull_low;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    prot_guard #(.OC_MASK(OCM), .TSD_MASK(TSDM), .ALM_MASK(ALMM)) u_dut (
        .clk(clk), .por_n(por_n), .standby_n(standby_n),
        .oc_raw(oc_raw), .tsd_raw(tsd_raw), .alm_hot(alm_hot),
        .alm_cool(alm_cool), .out_disable(out_disable),
        .err_pull_low(err_pull_low), .alm_pull_low(alm_pull_low)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic got, input logic exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    task automatic expect_out(input logic dis, input logic err, input logic alm, input string what);
        check(out_disable,  dis, {what, " out_disable"});
        check(err_pull_low, err, {what, " err_pull_low"});
        check(alm_pull_low, alm, {what, " alm_pull_low"});
    endtask

    task automatic quiet_clear();
        oc_raw = 0; tsd_raw = 0; alm_hot = 0; alm_cool = 0;
        standby_n = 0; tick(2);
        standby_n = 1; tick(1);
    endtask

    task automatic t_reset();
        por_n = 0; standby_n = 1; oc_raw = 0; tsd_raw = 0; alm_hot = 0; alm_cool = 0;
        tick(3);
        expect_out(1, 0, 0, "R7 in reset");
        por_n = 1; tick(1);
        expect_out(0, 0, 0, "R7 first edge after reset");
    endtask

    task automatic t_oc_trip();
        oc_raw = 1; tick(OCM);
        expect_out(0, 0, 0, "R1 oc at mask edge");
        tick(1);
        expect_out(1, 1, 0, "R1 oc accepted");
        check(err_pull_low && !out_disable, 0, "R5 err without disable");
        oc_raw = 0; tick(10);
        expect_out(1, 1, 0, "R4 latch after oc falls");
    endtask

    task automatic t_standby_clear();
        standby_n = 0; tick(1);
        expect_out(1, 0, 0, "R6 standby entry");
        standby_n = 1; tick(1);
        expect_out(0, 0, 0, "R6 standby exit");
    endtask

    task automatic t_tsd_trip();
        tsd_raw = 1; tick(TSDM);
        expect_out(0, 0, 0, "R2 tsd at mask edge");
        tick(1);
        expect_out(1, 1, 0, "R2 tsd accepted");
        tsd_raw = 0; tick(4);
        check(err_pull_low, 1, "R4 latch after tsd falls");
        quiet_clear();
    endtask

    task automatic t_glitch();
        oc_raw = 1; tick(OCM - 1); oc_raw = 0; tick(1);
        oc_raw = 1; tick(OCM - 1); oc_raw = 0; tick(3);
        expect_out(0, 0, 0, "R3 oc short runs");
        tsd_raw = 1; tick(TSDM - 1); tsd_raw = 0; tick(1);
        tsd_raw = 1; tick(TSDM - 1); tsd_raw = 0; tick(3);
        expect_out(0, 0, 0, "R3 tsd short runs");
    endtask

    task automatic t_hold_in_standby();
        standby_n = 0; oc_raw = 1; tick(40);
        expect_out(1, 0, 0, "R6 fault during standby");
        standby_n = 1; tick(OCM);
        expect_out(0, 0, 0, "R6 counter restarted after standby");
        tick(1);
        check(err_pull_low, 1, "R6 full count after standby");
        oc_raw = 0;
        quiet_clear();
    endtask

    task automatic t_alarm();
        alm_hot = 1; tick(ALMM);
        expect_out(0, 0, 0, "R8 alarm at mask edge");
        tick(1);
        expect_out(0, 0, 1, "R8 alarm raised, outputs stay on");
        alm_hot = 0; tick(5);
        check(alm_pull_low, 1, "R8 alarm held until cool");
        alm_cool = 1; tick(1);
        expect_out(0, 0, 0, "R8 alarm released");
        alm_cool = 0; tick(2);
        check(alm_pull_low, 0, "R8 no relatch");
    endtask

    task automatic t_cool_priority();
        alm_cool = 1; alm_hot = 1; tick(ALMM + 5);
        check(alm_pull_low, 0, "R9 cool blocks alarm");
        alm_cool = 0; tick(1);
        check(alm_pull_low, 1, "R9 warn after cool falls");
        alm_hot = 0; alm_cool = 1; tick(1);
        check(alm_pull_low, 0, "R9 cleared");
        alm_cool = 0; tick(1);
    endtask

    task automatic t_por_clear();
        oc_raw = 1; tick(OCM + 1);
        check(err_pull_low, 1, "R7 trip before reset");
        oc_raw = 0;
        #1 por_n = 0; #1;
        expect_out(1, 0, 0, "R7 async reset clears latch");
        tick(2); por_n = 1; tick(1);
        expect_out(0, 0, 0, "R7 run after reset");
    endtask

    initial begin
        t_reset();
        t_oc_trip();
        t_standby_clear();
        t_tsd_trip();
        t_glitch();
        t_hold_in_standby();
        t_alarm();
        t_cool_priority();
        t_por_clear();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule